// File: doc/BRIEF.md
# Least-Reliable-Bit Locator

This unit sits at the input of a soft-decision block decoder for a length-63 binary code. Soft values enter one per clock, highest code position first. Each value is split into two parts. The sign bit is the hard decision, and it is passed straight on to a syndrome stage. The lower bits are a reliability magnitude. In a single pass over the block, the unit finds the least reliable position in the upper half (positions 62..32) and the least reliable position in the lower half (positions 31..0).

Each position is reported as the field element alpha^i of GF(2^6), not as an index. This lets a downstream syndrome adder use it directly. A loop register produces alpha^i: it starts at alpha^62 and is multiplied by alpha^-1 for every accepted symbol. Two registers each hold a running minimum and its location, and only the one for the current half is active.

A small state machine sequences the scan. Its states are:
- `S_IDLE`: waiting for a block.
- `S_UPPER`: the upper half is being scanned.
- `S_LOWER`: the lower half is being scanned.
- `S_DONE`: a one-cycle completion state.

Its transitions are:
- From `S_IDLE` or `S_DONE`, a valid start strobe goes to `S_UPPER`. `S_DONE` otherwise falls back to `S_IDLE`.
- `S_UPPER` goes to `S_LOWER` when position 32 is accepted.
- `S_LOWER` goes to `S_DONE` when position 0 is accepted.
- A valid start strobe in any state restarts the scan in `S_UPPER`.

Top module: `lrb_locator`

## Requirements
- R1: `hd_bit` equals the most significant bit of `llr_in` and `hd_vld` equals `llr_vld`, both one clock after the input is presented.
- R2: The symbol presented with `llr_vld` and `llr_sob` both high is position 62. Each later cycle with `llr_vld` high carries the next lower position. Cycles with `llr_vld` low are skipped and do not advance the position.
- R3: After a block, `alpha_t0` holds alpha^i for the position i in 62..32 whose magnitude is smallest. The magnitude is the unsigned value of `llr_in[2:0]`.
- R4: After a block, `alpha_t1` holds alpha^i for the position i in 31..0 whose magnitude is smallest.
- R5: A stored location is replaced only when the incoming magnitude is strictly smaller than the stored minimum. On ties, the earliest (highest) position wins.
- R6: Both minima restart at 3'b111 with every block. A half in which every magnitude is 3'b111 reports alpha^62 (upper) or alpha^31 (lower).
- R7: Field elements use GF(2^6) with x^6+x+1. Bit k is the coefficient of alpha^k, so alpha^0 = 6'h01, alpha^6 = 6'h03 and alpha^62 = 6'h21.
- R8: `scan_done` is high for exactly one cycle, the cycle after position 0 is accepted. `alpha_t0` and `alpha_t1` then hold until the next start strobe.
- R9: A start strobe in the middle of a block discards the partial scan and begins afresh. A valid symbol without a start strobe while idle changes neither location output and raises no `scan_done`.
- R10: After reset, `scan_done` = 0, `hd_vld` = 0, `alpha_t0` = alpha^62 and `alpha_t1` = alpha^31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| llr_in | input | LLR_W (4) | Soft value: sign/hard bit on top, magnitude below |
| llr_vld | input | 1 | Soft value is valid this cycle |
| llr_sob | input | 1 | First symbol (position 62) of a block |
| hd_bit | output | 1 | Registered hard decision |
| hd_vld | output | 1 | Registered valid for `hd_bit` |
| alpha_t0 | output | 6 | alpha^t0, the weakest position in the upper half |
| alpha_t1 | output | 6 | alpha^t1, the weakest position in the lower half |
| scan_done | output | 1 | One-cycle pulse when both locations are final |

## Verification
The bench builds the block with its default parameters: 63 symbols, 4-bit soft values and the 6-bit field. With these values every position has a closed-form expected field element, so the half boundary at positions 32/31 and the ends at 62 and 0 can be aimed at directly. Tie cases, all-maximum halves, stalled blocks and restarts mid-block are all reachable within a few hundred cycles.

// File: rtl/lrb_pkg.sv
package lrb_pkg;

    localparam int          GF_M    = 6;
    localparam logic [GF_M:0] GF_POLY = 7'b1000011;

    typedef enum logic [1:0] {
        S_IDLE,
        S_UPPER,
        S_LOWER,
        S_DONE
    } scan_state_e;

    // multiply by alpha
    function automatic logic [GF_M-1:0] gf_mul_x(input logic [GF_M-1:0] v);
        return {v[GF_M-2:0], 1'b0} ^ (v[GF_M-1] ? GF_POLY[GF_M-1:0] : '0);
    endfunction

    // multiply by alpha^-1
    function automatic logic [GF_M-1:0] gf_div_x(input logic [GF_M-1:0] v);
        logic [GF_M-1:0] t;
        t = v ^ (v[0] ? GF_POLY[GF_M-1:0] : '0);
        return {v[0], t[GF_M-1:1]};
    endfunction

    function automatic logic [GF_M-1:0] gf_alpha_pow(input int n);
        logic [GF_M-1:0] v;
        v = {{(GF_M-1){1'b0}}, 1'b1};
        for (int k = 0; k < n; k++) v = gf_mul_x(v);
        return v;
    endfunction

endpackage

// File: rtl/lrb_alpha_loop.sv
module lrb_alpha_loop
    import lrb_pkg::*;
#(
    parameter logic [GF_M-1:0] START = 6'h21
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            step,
    output logic [GF_M-1:0] cur
);

    logic [GF_M-1:0] pow_q;

    // Current position's element: the start value on a block start, else the register.
    always_comb begin
        cur = load ? START : pow_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pow_q <= START;
        end else if (step) begin
            pow_q <= gf_div_x(cur);
        end
    end

endmodule

// File: rtl/lrb_min_track.sv
module lrb_min_track
    import lrb_pkg::*;
#(
    parameter int              MAG_W    = 3,
    parameter logic [GF_M-1:0] INIT_LOC = 6'h21
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    input  logic [MAG_W-1:0] mag,
    input  logic [GF_M-1:0]  loc_in,
    output logic [GF_M-1:0]  loc
);

    localparam logic [MAG_W-1:0] MAG_MAX = '1;

    logic [MAG_W-1:0] min_q;
    logic [GF_M-1:0]  loc_q;
    logic [MAG_W-1:0] ref_min;
    logic             hit;

    always_comb begin
        ref_min = clr ? MAG_MAX : min_q;
        hit     = en && (mag < ref_min);
        loc     = loc_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            min_q <= MAG_MAX;
            loc_q <= INIT_LOC;
        end else if (hit) begin
            min_q <= mag;
            loc_q <= loc_in;
        end else if (clr) begin
            min_q <= MAG_MAX;
            loc_q <= INIT_LOC;
        end
    end

endmodule

// File: rtl/lrb_locator.sv
module lrb_locator
    import lrb_pkg::*;
#(
    parameter int N_SYM = 63,
    parameter int LLR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LLR_W-1:0] llr_in,
    input  logic             llr_vld,
    input  logic             llr_sob,
    output logic             hd_bit,
    output logic             hd_vld,
    output logic [GF_M-1:0]  alpha_t0,
    output logic [GF_M-1:0]  alpha_t1,
    output logic             scan_done
);

    localparam int MAG_W = LLR_W - 1;
    localparam int IDX_W = $clog2(N_SYM);
    localparam int HALF  = (N_SYM - 1) / 2;
    localparam logic [IDX_W-1:0] IDX_TOP   = IDX_W'(N_SYM - 1);
    localparam logic [IDX_W-1:0] IDX_UPEND = IDX_W'(HALF + 1);
    localparam logic [GF_M-1:0]  LOC_TOP   = gf_alpha_pow(N_SYM - 1);
    localparam logic [GF_M-1:0]  LOC_MID   = gf_alpha_pow(HALF);

    scan_state_e state_q, state_nxt;

    logic             start;
    logic             consume;
    logic             upper_act;
    logic [IDX_W-1:0] idx_q, cur_idx;
    logic [GF_M-1:0]  cur_pow;
    logic [1:0]       en_half;
    logic [GF_M-1:0]  loc_half [2];
    logic             hd_bit_q, hd_vld_q;

    assign start = llr_vld && llr_sob;

    // next-state logic
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            S_IDLE, S_DONE: state_nxt = start ? S_UPPER : S_IDLE;
            S_UPPER: begin
                if (start)                              state_nxt = S_UPPER;
                else if (llr_vld && idx_q == IDX_UPEND) state_nxt = S_LOWER;
            end
            S_LOWER: begin
                if (start)                          state_nxt = S_UPPER;
                else if (llr_vld && idx_q == '0)    state_nxt = S_DONE;
            end
            default: state_nxt = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_nxt;
    end

    // state-decoded controls
    always_comb begin
        upper_act = start || (state_q == S_UPPER);
        consume   = start || (llr_vld && (state_q == S_UPPER || state_q == S_LOWER));
        en_half   = {consume && !upper_act, consume && upper_act};
        cur_idx   = start ? IDX_TOP : idx_q;
        scan_done = (state_q == S_DONE);
    end

    // position counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       idx_q <= IDX_TOP;
        else if (consume) idx_q <= cur_idx - 1'b1;
    end

    // hard-decision path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hd_bit_q <= 1'b0;
            hd_vld_q <= 1'b0;
        end else begin
            hd_bit_q <= llr_in[LLR_W-1];
            hd_vld_q <= llr_vld;
        end
    end

    assign hd_bit = hd_bit_q;
    assign hd_vld = hd_vld_q;

    lrb_alpha_loop #(.START(LOC_TOP)) u_loop (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start),
        .step  (consume),
        .cur   (cur_pow)
    );

    for (genvar h = 0; h < 2; h++) begin : g_half
        lrb_min_track #(
            .MAG_W    (MAG_W),
            .INIT_LOC ((h == 0) ? LOC_TOP : LOC_MID)
        ) u_trk (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (start),
            .en     (en_half[h]),
            .mag    (llr_in[MAG_W-1:0]),
            .loc_in (cur_pow),
            .loc    (loc_half[h])
        );
    end

    assign alpha_t0 = loc_half[0];
    assign alpha_t1 = loc_half[1];

endmodule

// File: rtl/lrb_locator_chk.sv
module lrb_locator_chk
    import lrb_pkg::*;
#(
    parameter int N_SYM = 63,
    parameter int LLR_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [LLR_W-1:0] llr_in,
    input logic             llr_vld,
    input logic             llr_sob,
    input logic             hd_bit,
    input logic             hd_vld,
    input logic [GF_M-1:0]  alpha_t0,
    input logic [GF_M-1:0]  alpha_t1,
    input logic             scan_done
);

    localparam int MAG_W = LLR_W - 1;
    localparam logic [GF_M-1:0] LOC_TOP = gf_alpha_pow(N_SYM - 1);

    p_hd_vld_r1: assert property (@(posedge clk) disable iff (!rst_n)
        llr_vld |=> hd_vld);
    p_hd_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !llr_vld |=> !hd_vld);
    p_hd_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        llr_vld |=> (hd_bit == $past(llr_in[LLR_W-1])));
    p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !llr_vld |=> ($stable(alpha_t0) && $stable(alpha_t1)));
    p_sob_default_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (llr_vld && llr_sob && llr_in[MAG_W-1:0] == '1) |=> (alpha_t0 == LOC_TOP));
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |=> !scan_done);
    p_done_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |-> $past(llr_vld));

    always @(posedge clk) begin
        if (rst_n) begin
            a_nonzero_r7: assert ((alpha_t0 != '0) && (alpha_t1 != '0));
        end
    end

endmodule

bind lrb_locator lrb_locator_chk #(.N_SYM(N_SYM), .LLR_W(LLR_W)) u_chk (.*);

// File: tb/tb_lrb_locator.sv
`timescale 1ns/1ps
module tb_lrb_locator;

    localparam int N = 63;
    localparam int NROW = 7;
    // each row: upper pos, upper mag, lower pos, lower mag, background mag, tie pos
    localparam int VEC [NROW][6] = '{
        '{50, 2, 10, 3, 6, -1},
        '{32, 0, 31, 0, 5, -1},
        '{62, 1,  0, 1, 4, -1},
        '{45, 3, 20, 3, 7, 40},
        '{-1, 0, -1, 0, 7, -1},
        '{40, 6,  5, 0, 7,  3},
        '{-1, 0,  6, 2, 7, -1}
    };

    logic       clk = 0;
    logic       rst_n = 0;
    logic [3:0] llr_in = '0;
    logic       llr_vld = 0;
    logic       llr_sob = 0;
    logic       hd_bit, hd_vld, scan_done;
    logic [5:0] alpha_t0, alpha_t1;

    int n_tests = 0;
    int n_fail  = 0;
    int mag_arr [N];
    bit hd_arr  [N];

    always #2 clk = ~clk;

    lrb_locator dut (
        .clk(clk), .rst_n(rst_n), .llr_in(llr_in), .llr_vld(llr_vld),
        .llr_sob(llr_sob), .hd_bit(hd_bit), .hd_vld(hd_vld),
        .alpha_t0(alpha_t0), .alpha_t1(alpha_t1), .scan_done(scan_done)
    );

    function automatic int apow(input int n);
        logic [5:0] v;
        v = 6'h01;
        for (int k = 0; k < n; k++) v = {v[4:0], 1'b0} ^ (v[5] ? 6'h03 : 6'h00);
        return int'(v);
    endfunction

    function automatic int weakest(input int hi, input int lo);
        int best, pos;
        best = 7; pos = hi;
        for (int i = hi; i >= lo; i--) if (mag_arr[i] < best) begin best = mag_arr[i]; pos = i; end
        return pos;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic fill(input int r);
        for (int i = 0; i < N; i++) begin
            if (i == VEC[r][0])      mag_arr[i] = VEC[r][1];
            else if (i == VEC[r][2]) mag_arr[i] = VEC[r][3];
            else if (i == VEC[r][5]) mag_arr[i] = (i > 31) ? VEC[r][1] : VEC[r][3];
            else                     mag_arr[i] = VEC[r][4];
            hd_arr[i] = bit'(i[0] ^ i[2] ^ r[0]);
        end
    endtask

    task automatic drive_block(input bit gaps, input string tag);
        int hd_bad = 0;
        for (int i = N - 1; i >= 0; i--) begin
            if (gaps && (i % 2 == 0)) begin
                llr_vld = 0; llr_sob = 0;
                @(negedge clk);
            end
            llr_vld = 1;
            llr_sob = (i == N - 1);
            llr_in  = {hd_arr[i], 3'(mag_arr[i])};
            @(negedge clk);
            if (!(hd_vld && hd_bit == hd_arr[i])) hd_bad++;
        end
        llr_vld = 0; llr_sob = 0;
        chk("R1", {tag, " hard bit stream errors"}, hd_bad, 0);
        chk("R8", {tag, " done after pos 0"}, int'(scan_done), 1);
        chk("R3", {tag, " alpha_t0"}, int'(alpha_t0), apow(weakest(62, 32)));
        chk("R4", {tag, " alpha_t1"}, int'(alpha_t1), apow(weakest(31, 0)));
        @(negedge clk);
        chk("R8", {tag, " done one cycle"}, int'(scan_done), 0);
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int t0s, t1s;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10", "done", int'(scan_done), 0);
        chk("R10", "hd_vld", int'(hd_vld), 0);
        chk("R10", "alpha_t0", int'(alpha_t0), apow(62));
        chk("R10", "alpha_t1", int'(alpha_t1), apow(31));
        rst_n = 1;
        @(negedge clk);

        // table walk: R3 R4 R5 R6
        for (int r = 0; r < NROW; r++) begin
            fill(r);
            drive_block(1'b0, $sformatf("row%0d", r));
        end

        // R7 literal encodings and R8 hold after last row
        repeat (5) @(negedge clk);
        chk("R7", "alpha^62 literal", int'(alpha_t0), 'h21);
        chk("R7", "alpha^6 literal", int'(alpha_t1), 'h03);
        chk("R6", "all-max upper default", int'(alpha_t0), apow(62));

        // R9 idle symbols without start are ignored
        t0s = int'(alpha_t0); t1s = int'(alpha_t1);
        begin
            int done_seen = 0;
            for (int k = 0; k < 8; k++) begin
                llr_vld = 1; llr_sob = 0; llr_in = 4'b1000;
                @(negedge clk);
                if (scan_done) done_seen++;
            end
            llr_vld = 0;
            chk("R1", "hd_vld follows idle valid", int'(hd_vld), 1);
            @(negedge clk);
            chk("R9", "idle no done", done_seen, 0);
            chk("R9", "idle t0 unchanged", int'(alpha_t0), t0s);
            chk("R9", "idle t1 unchanged", int'(alpha_t1), t1s);
        end

        // R2 block with stall cycles
        fill(0);
        mag_arr[40] = 1; mag_arr[7] = 2;
        drive_block(1'b1, "stall R2");

        // R9 restart mid-block
        for (int i = 0; i < N; i++) begin mag_arr[i] = 5; hd_arr[i] = 0; end
        for (int i = N - 1; i > 42; i--) begin
            llr_vld = 1; llr_sob = (i == N - 1);
            llr_in  = {1'b0, (i == 55) ? 3'd0 : 3'd5};
            @(negedge clk);
        end
        mag_arr[33] = 4; mag_arr[2] = 4; mag_arr[1] = 4;
        drive_block(1'b0, "restart R9");
        chk("R5", "tie in lower keeps higher pos", int'(alpha_t1), apow(2));

        summary();
        $finish;
    end

endmodule